// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block decides, for each of four differential clock outputs, whether the output pair toggles or is parked with both legs low. It runs from the reference clock. From that clock it makes a divided output clock, whose high and low phases each last `HALF` reference cycles, and it drives the true and complement legs of every channel from it. A channel toggles only when three conditions all hold: the power-good sequence has finished, the channel's register enable bit is 1, and the channel's active-low enable pin is 0. The register bits arrive as plain inputs.

Every control input crosses into the clock domain through a two-flop synchronizer. A channel's gate may change only at the boundary between a low phase and the next high phase. A stopping channel therefore always finishes a complete low phase, and a starting channel always opens with a complete high phase, so no output ever carries a shortened pulse. The power-good input sequences the block. After reset it waits for a true rising edge, then runs a restart interval of `RESTART_CYC` reference cycles before the outputs are released. A later low level puts the block into power-down, and the next high level runs the restart interval again.

Top module: `dcg_ctrl`

## Requirements
- R1: After reset all true and complement outputs and all `run_o` bits are 0 and `pwrdn_o` is 1. A power-good input that is already high during reset does not start the block; only a low-to-high transition seen after reset does.
- R2: Within 3·P+4 reference cycles of power-good going low (P = 2·HALF, the output period), every channel holds both legs at 0 and `pwrdn_o` is 1, whatever the enable pins and register bits are.
- R3: After power-good returns high, all outputs stay at 0 for at least `RESTART_CYC` reference cycles. Within 3·P+4 further cycles, enabled channels toggle again and `pwrdn_o` is 0.
- R4: While running, channel i toggles if and only if `en_reg_i[i]`=1 and `en_pin_n_i[i]`=0. A pin value of 1 disables the channel, and 0 (the pulled-low default of a floating pin) enables it.
- R5: A register bit of 0 forces both legs of its channel to 0 even when its pin is 0.
- R6: A channel starts or stops between P and 3·P reference cycles after its enable pin changes. That is 1 to 3 output clock periods.
- R7: Every high pulse on a true or complement leg lasts exactly HALF reference cycles, including the first pulse after a start and the last pulse before a stop. A start always begins with the true leg high.
- R8: `run_o[i]` is 1 while channel i is toggling and 0 while it is parked.
- R9: A channel's gate changes only at the low-to-high phase boundary of the output clock.
- R10: While a channel toggles, its true and complement legs are always opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwrgd_i | input | 1 | Power-good / power-down control, asynchronous |
| en_pin_n_i | input | NCH | Active-low per-channel enable pins, asynchronous |
| en_reg_i | input | NCH | Per-channel register enable bits, asynchronous |
| clk_t_o | output | NCH | True leg of each output clock |
| clk_c_o | output | NCH | Complement leg of each output clock |
| run_o | output | NCH | Per-channel gate state |
| pwrdn_o | output | 1 | 1 whenever the block is not in its running state |

## Verification
The hardest case to reach is a power-good level that is already high when reset is released. It must not count as a start edge, so the stimulus holds the input high through reset and watches the outputs stay quiet before it pulses the input low and high. The second hard case is an enable change that lands anywhere inside the output period. A full sweep of all 256 pin and register combinations moves the change point relative to the phase counter. Meanwhile a pulse-width monitor runs for the whole test and checks every completed high pulse on every leg, so a clipped first or last pulse would show up.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [1:0] {
        PG_WAIT    = 2'd0,
        PG_RESTART = 2'd1,
        PG_RUN     = 2'd2,
        PG_DOWN    = 2'd3
    } pg_state_e;

    typedef struct packed {
        logic t;
        logic c;
    } leg_pair_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dcg_sync.sv
module dcg_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/dcg_phase.sv
module dcg_phase
    import dcg_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ph_hi_o,
    output logic at_bndry_o
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned CW     = cnt_w(PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (cnt_q == CW'(PERIOD - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign ph_hi_o    = (cnt_q < CW'(HALF));
    assign at_bndry_o = (cnt_q == CW'(PERIOD - 1));

    // R7
    phase_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(cnt_q) < PERIOD);

    // R9
    bndry_then_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        at_bndry_o |=> ph_hi_o);
endmodule

// File: rtl/dcg_pwr_fsm.sv
module dcg_pwr_fsm
    import dcg_pkg::*;
#(
    parameter int unsigned RESTART_CYC = 30000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pg_s_i,
    output logic run_o,
    output logic pwrdn_o
);
    localparam int unsigned RW = cnt_w(RESTART_CYC);

    pg_state_e     state_q, state_d;
    logic          pg_prev_q;
    logic [RW-1:0] rcnt_q;
    logic          pg_rise;

    assign pg_rise = pg_s_i && !pg_prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_WAIT:    if (pg_rise) state_d = PG_RESTART;
            PG_RESTART: begin
                if (!pg_s_i)                             state_d = PG_DOWN;
                else if (rcnt_q == RW'(RESTART_CYC - 1)) state_d = PG_RUN;
            end
            PG_RUN:     if (!pg_s_i) state_d = PG_DOWN;
            PG_DOWN:    if (pg_s_i)  state_d = PG_RESTART;
            default:    state_d = PG_WAIT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= PG_WAIT;
            pg_prev_q <= 1'b1;
            rcnt_q    <= '0;
        end else begin
            state_q   <= state_d;
            pg_prev_q <= pg_s_i;
            if (state_d == PG_RESTART && state_q != PG_RESTART)
                rcnt_q <= '0;
            else if (state_q == PG_RESTART)
                rcnt_q <= rcnt_q + 1'b1;
        end
    end

    assign run_o   = (state_q == PG_RUN);
    assign pwrdn_o = (state_q != PG_RUN);

    // R2
    run_needs_pg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PG_RUN) |-> $past(pg_s_i));

    // R2
    pg_fall_stops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pg_s_i) |=> (state_q == PG_WAIT || state_q == PG_DOWN));

    // R3
    restart_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PG_RESTART) |-> (32'(rcnt_q) < RESTART_CYC));

    // R1
    wait_no_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PG_WAIT) |=> (state_q != PG_RUN));
endmodule

// File: rtl/dcg_lane.sv
module dcg_lane
    import dcg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      at_bndry_i,
    input  logic      ph_hi_i,
    input  logic      req_i,
    output leg_pair_t legs_o,
    output logic      run_o
);
    logic req_q;
    logic gate_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q  <= 1'b0;
            gate_q <= 1'b0;
        end else if (at_bndry_i) begin
            req_q  <= req_i;
            gate_q <= req_q;
        end
    end

    assign legs_o.t = ph_hi_i & gate_q;
    assign legs_o.c = ~ph_hi_i & gate_q;
    assign run_o    = gate_q;

    // R9
    gate_at_bndry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_q != $past(gate_q)) |-> $past(at_bndry_i));

    // R7
    start_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_q) |-> ph_hi_i);
endmodule

// File: rtl/dcg_ctrl.sv
module dcg_ctrl
    import dcg_pkg::*;
#(
    parameter int unsigned NCH         = 4,
    parameter int unsigned HALF        = 2,
    parameter int unsigned RESTART_CYC = 30000
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           pwrgd_i,
    input  logic [NCH-1:0] en_pin_n_i,
    input  logic [NCH-1:0] en_reg_i,
    output logic [NCH-1:0] clk_t_o,
    output logic [NCH-1:0] clk_c_o,
    output logic [NCH-1:0] run_o,
    output logic           pwrdn_o
);
    logic [NCH-1:0] pin_n_s, reg_s;
    logic           pg_s;
    logic           ph_hi, at_bndry;
    logic           pwr_run;

    dcg_sync #(.W(NCH), .RST_VAL('0)) pin_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(en_pin_n_i), .q_o(pin_n_s));

    dcg_sync #(.W(NCH), .RST_VAL('0)) reg_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(en_reg_i), .q_o(reg_s));

    dcg_sync #(.W(1), .RST_VAL(1'b1)) pg_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(pwrgd_i), .q_o(pg_s));

    dcg_pwr_fsm #(.RESTART_CYC(RESTART_CYC)) pwr_i (
        .clk_i(clk_i), .rst_i(rst_i), .pg_s_i(pg_s),
        .run_o(pwr_run), .pwrdn_o(pwrdn_o));

    dcg_phase #(.HALF(HALF)) phase_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .ph_hi_o(ph_hi), .at_bndry_o(at_bndry));

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        leg_pair_t legs;
        logic      req;

        assign req = pwr_run & reg_s[g] & ~pin_n_s[g];

        dcg_lane lane_i (
            .clk_i(clk_i), .rst_i(rst_i),
            .at_bndry_i(at_bndry), .ph_hi_i(ph_hi),
            .req_i(req), .legs_o(legs), .run_o(run_o[g]));

        assign clk_t_o[g] = legs.t;
        assign clk_c_o[g] = legs.c;

        // R10
        legs_opposite_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            run_o[g] |-> (clk_t_o[g] != clk_c_o[g]));
    end
endmodule

// File: tb/dcg_ctrl_tb_top.sv
module dcg_ctrl_tb_top;
    localparam int NCH  = 4;
    localparam int HALF = 2;
    localparam int P    = 2 * HALF;
    localparam int RC   = 20;
    localparam int SETTLE = 3 * P + 4;

    logic clk = 1'b0;
    logic rst;
    logic pwrgd;
    logic [NCH-1:0] pin_n, regb;
    logic [NCH-1:0] t_o, c_o, run;
    logic pwrdn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dcg_ctrl #(.NCH(NCH), .HALF(HALF), .RESTART_CYC(RC)) dut_i (
        .clk_i(clk), .rst_i(rst), .pwrgd_i(pwrgd),
        .en_pin_n_i(pin_n), .en_reg_i(regb),
        .clk_t_o(t_o), .clk_c_o(c_o), .run_o(run), .pwrdn_o(pwrdn));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // pulse-width monitor, R7
    int tlen [NCH];
    int clen [NCH];
    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst) begin
                tlen[i] = 0;
                clen[i] = 0;
            end else begin
                if (t_o[i]) tlen[i]++;
                else if (tlen[i] != 0) begin
                    chk(tlen[i] == HALF, "R7", "true pulse width", tlen[i], HALF);
                    tlen[i] = 0;
                end
                if (c_o[i]) clen[i]++;
                else if (clen[i] != 0) begin
                    chk(clen[i] == HALF, "R7", "complement pulse width", clen[i], HALF);
                    clen[i] = 0;
                end
            end
        end
    end

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic observe(input int n, output logic [NCH-1:0] act,
                           output logic [NCH-1:0] idle, output logic [NCH-1:0] runhi,
                           output logic [NCH-1:0] runlo, output logic [NCH-1:0] anti);
        logic [NCH-1:0] st, sc;
        st = '0; sc = '0; idle = '1; runhi = '1; runlo = '1; anti = '1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            st    |= t_o;
            sc    |= c_o;
            idle  &= ~(t_o | c_o);
            runhi &= run;
            runlo &= ~run;
            anti  &= (t_o ^ c_o);
        end
        act = st & sc;
    endtask

    initial begin
        logic [NCH-1:0] act, idle, rh, rl, an, exp_act;
        int first, last;
        rst = 1'b1; pwrgd = 1'b1; pin_n = '0; regb = '1;
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(t_o == 0 && c_o == 0, "R1", "outputs after reset", int'({t_o, c_o}), 0);
        chk(run == 0, "R1", "run_o after reset", int'(run), 0);
        chk(pwrdn == 1'b1, "R1", "pwrdn_o after reset", int'(pwrdn), 1);
        // R1 high level through reset is not a start edge
        observe(100, act, idle, rh, rl, an);
        chk(idle == '1, "R1", "quiet with power-good held high", int'(idle), 15);
        chk(pwrdn == 1'b1, "R1", "pwrdn_o without edge", int'(pwrdn), 1);

        // first rising edge, R3
        pwrgd = 1'b0; cycles(10);
        pwrgd = 1'b1;
        observe(RC, act, idle, rh, rl, an);
        chk(idle == '1, "R3", "quiet during restart interval", int'(idle), 15);
        cycles(SETTLE);
        observe(2 * P, act, idle, rh, rl, an);
        chk(act == '1, "R3", "channels toggle after restart", int'(act), 15);
        chk(pwrdn == 1'b0, "R3", "pwrdn_o after restart", int'(pwrdn), 0);

        // R4 R5 R8 R10 exhaustive sweep
        for (int v = 0; v < 256; v++) begin
            pin_n = v[3:0];
            regb  = v[7:4];
            exp_act = regb & ~pin_n;
            cycles(SETTLE);
            observe(2 * P, act, idle, rh, rl, an);
            for (int i = 0; i < NCH; i++) begin
                if (exp_act[i]) begin
                    chk(act[i], "R4", "channel toggles when enabled", int'(act[i]), 1);
                    chk(rh[i], "R8", "run_o high while toggling", int'(rh[i]), 1);
                    chk(an[i], "R10", "legs opposite", int'(an[i]), 1);
                end else begin
                    if (!regb[i] && !pin_n[i])
                        chk(idle[i], "R5", "register bit 0 overrides pin", int'(idle[i]), 1);
                    else
                        chk(idle[i], "R4", "channel parked when disabled", int'(idle[i]), 1);
                    chk(rl[i], "R8", "run_o low while parked", int'(rl[i]), 0 + 1);
                end
            end
        end

        // R6 latency, R7 start with true high
        regb = '1; pin_n = '1;
        cycles(SETTLE);
        for (int i = 0; i < NCH; i++) begin
            pin_n[i] = 1'b0;
            first = -1;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (first < 0 && (t_o[i] | c_o[i])) begin
                    first = k;
                    chk(t_o[i] && !c_o[i], "R7", "start opens with true high",
                        int'({t_o[i], c_o[i]}), 2);
                end
            end
            chk(first >= P && first <= 3 * P, "R6", "start latency", first, P);
            pin_n[i] = 1'b1;
            last = 0;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (t_o[i] | c_o[i]) last = k;
            end
            chk(last + 1 >= P && last + 1 <= 3 * P, "R6", "stop latency", last + 1, P);
        end

        // R2 power-down overrides enables
        pin_n = '0; regb = '1;
        cycles(SETTLE);
        pwrgd = 1'b0;
        cycles(SETTLE);
        observe(4 * P, act, idle, rh, rl, an);
        chk(idle == '1, "R2", "quiet in power-down", int'(idle), 15);
        chk(pwrdn == 1'b1, "R2", "pwrdn_o in power-down", int'(pwrdn), 1);
        chk(rl == '1, "R2", "run_o low in power-down", int'(rl), 15);

        // R3 level exit from power-down
        pwrgd = 1'b1;
        observe(RC, act, idle, rh, rl, an);
        chk(idle == '1, "R3", "quiet during second restart", int'(idle), 15);
        cycles(SETTLE);
        observe(2 * P, act, idle, rh, rl, an);
        chk(act == '1, "R3", "resume after power-down", int'(act), 15);
        chk(pwrdn == 1'b0, "R3", "pwrdn_o after resume", int'(pwrdn), 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule